// File: doc/BRIEF.md
# Sensor Register Slave on a Two-Wire Bus

This block is a two-wire serial slave that exposes the register set of a small temperature sensor. It holds a two-bit register pointer and four registers: a read-only 16-bit temperature word taken straight from an input port, two writable 16-bit limit words (an upper trip level and a release level), and a writable 8-bit configuration byte. Both bus lines are oversampled in the system clock domain. The block recognises start, repeated start and stop, answers one 7-bit address, and acknowledges the bytes it accepts.

A controller writes by sending the address with the direction bit clear, then a pointer byte, then the data bytes for the selected register. To read, it either addresses the slave with the direction bit set, which reads the register the pointer already selects, or it sets the pointer and then issues a repeated start with a read address. The width of a register sets how many bytes move: one for the configuration byte, two for the others. A 16-bit read always runs to completion, even when the controller declines the first byte.

Top module: `snsr_i2c_slave`

## Requirements
- R1: While and after synchronous reset, SDA is released (`sda_oe` = 0), `cfg_out` = CFG_RST, `over_out` = OVER_RST, `hyst_out` = HYST_RST, and the pointer selects the temperature word.
- R2: The slave answers the 7-bit address {ADDR_HI, addr_sel[2:0]} followed by the direction bit (1 = read). On a match it pulls SDA low for the ninth clock. On any other address it leaves SDA released for every clock until the next start.
- R3: In a write transaction the first byte after the address is the pointer byte. It is acknowledged, and its bits [1:0] select 00 temperature, 01 configuration, 10 release level, 11 upper level. The pointer keeps its value across transactions.
- R4: Data bytes that follow the pointer byte in the same transaction write the selected register. The configuration byte takes one byte. A limit word takes two bytes, most significant first. Each byte is acknowledged. The register output updates within a few system clocks after the last byte's eighth SCL falling edge.
- R5: A 16-bit write that ends after only one data byte leaves the register unchanged.
- R6: Data written with the pointer at the temperature word is acknowledged, and no register output changes.
- R7: With the direction bit set, the slave drives the selected register onto SDA, most significant bit first, starting with the clock after its address acknowledge. It sends two bytes for the temperature and limit words and one byte for the configuration. The temperature bytes come from one sample of `temp_in`, taken when the address acknowledge ends.
- R8: A pointer byte, then a repeated start and the read address, returns the contents of the newly selected register.
- R9: After a not-acknowledge on the first byte of a 16-bit read, the slave still shifts out the second byte. While it drives a 0 data bit, the bus stays low and a stop attempt has no effect. After that byte's ninth clock, SDA is released and a stop returns the slave to idle.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 3 | Strap pins that set the low three address bits |
| temp_in | input | 16 | Temperature word presented for reading |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_out | output | 8 | Configuration register |
| over_out | output | 16 | Upper trip level register |
| hyst_out | output | 16 | Release level register |

## Verification
The bench keeps the default two-stage synchronizer and upper address nibble 1001. It overrides the configuration reset value to 8'h18, so a reset check can tell a reset byte apart from a cleared one. The straps are set to 101, which lets a controller address that differs only in the strap bits (100) show that the slave stays silent. The release-level value 16'h3C00 has a low byte of all zeros, so the SDA lock-up after a cut-short read holds the line low for every bit of the second byte.

// File: rtl/snsr_i2c_pkg.sv
package snsr_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_HYST = 2'b10,
    SEL_OVER = 2'b11
  } sel_t;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_PTR, PH_WDAT, PH_RACK, PH_TX, PH_TACK, PH_DONE
  } ph_t;

  function automatic logic sel_wide(input sel_t s);
    return s != SEL_CFG;
  endfunction
endpackage

// File: rtl/snsr_i2c_lines.sv
module snsr_i2c_lines #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_hit,
  output logic stop_hit
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_hit = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_hit  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/snsr_i2c_regs.sv
module snsr_i2c_regs
  import snsr_i2c_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_RST  = 8'h00,
  parameter logic [WORD_W-1:0] OVER_RST = 16'h5000,
  parameter logic [WORD_W-1:0] HYST_RST = 16'h4B00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  sel_t              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] temp_in,
  input  sel_t              rd_sel,
  output logic [WORD_W-1:0] rd_word,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [WORD_W-1:0] over_q,
  output logic [WORD_W-1:0] hyst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= CFG_RST;
      over_q <= OVER_RST;
      hyst_q <= HYST_RST;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_CFG:  cfg_q  <= wr_data[BYTE_W-1:0];
        SEL_HYST: hyst_q <= wr_data;
        SEL_OVER: over_q <= wr_data;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CFG:  rd_word = {{(WORD_W-BYTE_W){1'b0}}, cfg_q};
      SEL_HYST: rd_word = hyst_q;
      SEL_OVER: rd_word = over_q;
      default:  rd_word = temp_in;
    endcase
  end

  assert_temp_wr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_TEMP) |=> ($stable(cfg_q) && $stable(over_q) && $stable(hyst_q)));

  assert_over_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(over_q) |-> $past(wr_en && wr_sel == SEL_OVER));

  assert_hyst_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(hyst_q) |-> $past(wr_en && wr_sel == SEL_HYST));
endmodule

// File: rtl/snsr_i2c_fsm.sv
module snsr_i2c_fsm
  import snsr_i2c_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter int         STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_q,
  input  logic               sda_q,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_hit,
  input  logic               stop_hit,
  input  logic [STRAP_W-1:0] addr_sel,
  input  logic [WORD_W-1:0]  rd_word,
  output sel_t               ptr,
  output logic               wr_en,
  output sel_t               wr_sel,
  output logic [WORD_W-1:0]  wr_data,
  output logic               sda_oe
);
  ph_t               ph;
  logic [2:0]        bitcnt;
  logic              byte_done;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hold;
  logic [WORD_W-1:0] tx_word;
  logic [1:0]        idx;
  logic              rw;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      bitcnt    <= '0;
      byte_done <= 1'b0;
      shreg     <= '0;
      hold      <= '0;
      tx_word   <= '0;
      idx       <= '0;
      rw        <= 1'b0;
      ptr       <= SEL_TEMP;
      wr_en     <= 1'b0;
      wr_sel    <= SEL_TEMP;
      wr_data   <= '0;
      sda_oe    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_hit) begin
        ph        <= PH_ADDR;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_hit) begin
        ph     <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (ph)
          PH_ADDR, PH_PTR, PH_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_q};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              bitcnt    <= '0;
              if (ph == PH_ADDR) begin
                if (shreg[BYTE_W-1:1] == {ADDR_HI, addr_sel}) begin
                  rw     <= shreg[0];
                  sda_oe <= 1'b1;
                  ph     <= PH_AACK;
                end else begin
                  ph <= PH_IDLE;
                end
              end else if (ph == PH_PTR) begin
                ptr    <= sel_t'(shreg[1:0]);
                idx    <= '0;
                sda_oe <= 1'b1;
                ph     <= PH_RACK;
              end else begin
                sda_oe <= 1'b1;
                ph     <= PH_RACK;
                if (sel_wide(ptr)) begin
                  if (idx == 2'd0) hold <= shreg;
                  else if (idx == 2'd1) begin
                    wr_en   <= 1'b1;
                    wr_sel  <= ptr;
                    wr_data <= {hold, shreg};
                  end
                end else if (idx == 2'd0) begin
                  wr_en   <= 1'b1;
                  wr_sel  <= ptr;
                  wr_data <= {{(WORD_W-BYTE_W){1'b0}}, shreg};
                end
                if (idx != 2'd2) idx <= idx + 2'd1;
              end
            end
          end
          PH_AACK: if (scl_fall) begin
            if (rw) begin
              tx_word <= sel_wide(ptr) ? rd_word : {rd_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
              sda_oe  <= sel_wide(ptr) ? ~rd_word[WORD_W-1] : ~rd_word[BYTE_W-1];
              idx     <= '0;
              bitcnt  <= '0;
              ph      <= PH_TX;
            end else begin
              sda_oe <= 1'b0;
              ph     <= PH_PTR;
            end
          end
          PH_RACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            ph     <= PH_WDAT;
          end
          PH_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall) begin
              tx_word <= {tx_word[WORD_W-2:0], 1'b0};
              if (byte_done) begin
                byte_done <= 1'b0;
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                ph        <= PH_TACK;
              end else begin
                sda_oe <= ~tx_word[WORD_W-2];
              end
            end
          end
          PH_TACK: if (scl_fall) begin
            if (sel_wide(ptr) && idx == 2'd0) begin
              idx    <= 2'd1;
              sda_oe <= ~tx_word[WORD_W-1];
              ph     <= PH_TX;
            end else begin
              ph <= PH_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_drives_low_R2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_AACK || ph == PH_RACK) |-> sda_oe);

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_q));

  assert_ptr_from_ptr_byte_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(ph == PH_PTR && scl_fall));

  assert_released_in_ack_slot_R9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_TACK || ph == PH_DONE || ph == PH_IDLE) |-> !sda_oe);
endmodule

// File: rtl/snsr_i2c_slave.sv
module snsr_i2c_slave
  import snsr_i2c_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [3:0]        ADDR_HI     = 4'b1001,
  parameter logic [BYTE_W-1:0] CFG_RST     = 8'h00,
  parameter logic [WORD_W-1:0] OVER_RST    = 16'h5000,
  parameter logic [WORD_W-1:0] HYST_RST    = 16'h4B00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        addr_sel,
  input  logic [WORD_W-1:0] temp_in,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] cfg_out,
  output logic [WORD_W-1:0] over_out,
  output logic [WORD_W-1:0] hyst_out
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_hit, stop_hit;
  logic wr_en;
  sel_t ptr, wr_sel;
  logic [WORD_W-1:0] wr_data, rd_word;

  snsr_i2c_lines #(.STAGES(SYNC_STAGES)) u_lines (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_hit(start_hit), .stop_hit(stop_hit)
  );

  snsr_i2c_fsm #(.ADDR_HI(ADDR_HI), .STRAP_W(3)) u_fsm (
    .clk(clk), .rst(rst), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_hit(start_hit), .stop_hit(stop_hit),
    .addr_sel(addr_sel), .rd_word(rd_word), .ptr(ptr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  snsr_i2c_regs #(.CFG_RST(CFG_RST), .OVER_RST(OVER_RST), .HYST_RST(HYST_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .temp_in(temp_in), .rd_sel(ptr), .rd_word(rd_word),
    .cfg_q(cfg_out), .over_q(over_out), .hyst_q(hyst_out)
  );
endmodule

// File: tb/snsr_i2c_slave_tb.sv
module snsr_i2c_slave_tb;
  localparam int Q = 10;
  localparam logic [7:0]  CFG_R  = 8'h18;
  localparam logic [15:0] OVER_R = 16'h5000;
  localparam logic [15:0] HYST_R = 16'h4B00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic [15:0] temp_w = 16'h1A55;
  logic        sda_oe;
  logic [7:0]  cfg_out;
  logic [15:0] over_out, hyst_out;
  logic        bus_sda;
  assign bus_sda = m_sda & ~sda_oe;

  snsr_i2c_slave #(.CFG_RST(CFG_R), .OVER_RST(OVER_R), .HYST_RST(HYST_R)) u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(bus_sda), .addr_sel(strap),
    .temp_in(temp_w), .sda_oe(sda_oe), .cfg_out(cfg_out),
    .over_out(over_out), .hyst_out(hyst_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [7:0]  cfg_m;
  logic [15:0] over_m, hyst_m;
  int  grace = 0;
  bit  mon_on = 1'b0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (mon_on) begin
      if (grace > 0) grace--;
      else begin
        chk(cfg_out == cfg_m, "R4/R5/R6 cfg_out", {8'h00, cfg_out}, {8'h00, cfg_m});
        chk(over_out == over_m, "R4/R5/R6 over_out", over_out, over_m);
        chk(hyst_out == hyst_m, "R4/R5/R6 hyst_out", hyst_out, hyst_m);
      end
      if (m_scl && scl_prev) chk(sda_oe == oe_prev, "R10 drive moved with SCL high", {15'd0, sda_oe}, {15'd0, oe_prev});
      scl_prev = m_scl;
      oe_prev  = sda_oe;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic r);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    r = bus_sda; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic start_c();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    chk(r == !exp_ack, req, {15'd0, r}, {15'd0, !exp_ack});
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      chk(r == exp[i], req, {15'd0, r}, {15'd0, exp[i]});
    end
    bit_io(mack ? 1'b0 : 1'b1, r);
  endtask

  function automatic void model_wr(input logic [1:0] p, input logic [15:0] d);
    case (p)
      2'b01: cfg_m = d[7:0];
      2'b10: hyst_m = d;
      2'b11: over_m = d;
      default: ;
    endcase
  endfunction

  task automatic wr_reg(input logic [1:0] p, input logic [15:0] d, input bit wide, input string req);
    start_c();
    send_byte({4'b1001, strap, 1'b0}, 1'b1, "R2 address ack");
    send_byte({6'd0, p}, 1'b1, "R3 pointer ack");
    if (wide) send_byte(d[15:8], 1'b1, req);
    model_wr(p, d);
    grace = 9 * 4 * Q + 20;
    send_byte(d[7:0], 1'b1, req);
    stop_c();
  endtask

  task automatic rd_reg(input logic [1:0] p, input bit setp, input logic [15:0] exp, input bit wide, input string req);
    start_c();
    if (setp) begin
      send_byte({4'b1001, strap, 1'b0}, 1'b1, "R2 address ack");
      send_byte({6'd0, p}, 1'b1, "R3 pointer ack");
      start_c();
    end
    send_byte({4'b1001, strap, 1'b1}, 1'b1, "R2 read address ack");
    if (wide) begin
      recv_byte(exp[15:8], 1'b1, req);
      recv_byte(exp[7:0], 1'b0, req);
    end else begin
      recv_byte(exp[7:0], 1'b0, req);
    end
    stop_c();
  endtask

  initial begin
    logic r;
    cfg_m  = CFG_R;
    over_m = OVER_R;
    hyst_m = HYST_R;
    wq(6);
    chk(sda_oe == 1'b0, "R1 released in reset", {15'd0, sda_oe}, 16'd0);
    rst = 1'b0;
    wq(3);
    chk(sda_oe == 1'b0, "R1 released after reset", {15'd0, sda_oe}, 16'd0);
    chk(cfg_out == CFG_R, "R1 cfg reset", {8'd0, cfg_out}, {8'd0, CFG_R});
    chk(over_out == OVER_R, "R1 upper reset", over_out, OVER_R);
    chk(hyst_out == HYST_R, "R1 release reset", hyst_out, HYST_R);
    mon_on = 1'b1;

    // R1 R7: pointer starts at temperature, read without pointer set
    rd_reg(2'b00, 1'b0, 16'h1A55, 1'b1, "R7 R1 temperature read");

    // R4: writes of all three writable registers
    wr_reg(2'b11, 16'h7F80, 1'b1, "R4 upper write ack");
    chk(over_out == 16'h7F80, "R4 upper value", over_out, 16'h7F80);
    wr_reg(2'b10, 16'h3C00, 1'b1, "R4 release write ack");
    chk(hyst_out == 16'h3C00, "R4 release value", hyst_out, 16'h3C00);
    wr_reg(2'b01, 16'h00A5, 1'b0, "R4 cfg write ack");
    chk(cfg_out == 8'hA5, "R4 cfg value", {8'd0, cfg_out}, 16'h00A5);

    // R8: pointer set then repeated start read
    rd_reg(2'b11, 1'b1, 16'h7F80, 1'b1, "R8 upper readback");
    rd_reg(2'b01, 1'b1, 16'h00A5, 1'b0, "R8 R7 cfg single byte");
    // R3: pointer persists into the next transaction
    rd_reg(2'b01, 1'b0, 16'h00A5, 1'b0, "R3 pointer persists");

    // R6: temperature write acknowledged and ignored
    temp_w = 16'h2B31;
    wr_reg(2'b00, 16'hFFFF, 1'b1, "R6 temperature write ack");
    chk(over_out == 16'h7F80 && hyst_out == 16'h3C00 && cfg_out == 8'hA5,
        "R6 registers untouched", over_out, 16'h7F80);
    rd_reg(2'b00, 1'b0, 16'h2B31, 1'b1, "R6 R7 temperature after write");

    // R5: 16-bit write cut after one byte
    start_c();
    send_byte({4'b1001, strap, 1'b0}, 1'b1, "R2 address ack");
    send_byte(8'h03, 1'b1, "R3 pointer ack");
    send_byte(8'h12, 1'b1, "R5 single byte ack");
    stop_c();
    wq(20);
    chk(over_out == 16'h7F80, "R5 upper unchanged", over_out, 16'h7F80);

    // R2: address mismatch in strap bits, then in upper nibble
    start_c();
    send_byte({4'b1001, 3'b100, 1'b0}, 1'b0, "R2 strap mismatch no ack");
    send_byte(8'h00, 1'b0, "R2 released after mismatch");
    stop_c();
    start_c();
    send_byte({4'b1000, strap, 1'b1}, 1'b0, "R2 nibble mismatch no ack");
    recv_byte(8'hFF, 1'b0, "R2 no data after mismatch");
    stop_c();

    // R9: cut-short 16-bit read of 16'h3C00
    start_c();
    send_byte({4'b1001, strap, 1'b0}, 1'b1, "R2 address ack");
    send_byte(8'h02, 1'b1, "R3 pointer ack");
    start_c();
    send_byte({4'b1001, strap, 1'b1}, 1'b1, "R2 read address ack");
    recv_byte(8'h3C, 1'b0, "R9 first byte");
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
    chk(bus_sda == 1'b0, "R9 line held low through stop attempt", {15'd0, bus_sda}, 16'd0);
    chk(sda_oe == 1'b1, "R9 slave still driving", {15'd0, sda_oe}, 16'd1);
    m_scl = 1'b0; wq(Q);
    for (int i = 0; i < 7; i++) begin
      bit_io(1'b1, r);
      chk(r == 1'b0, "R9 second byte still shifted", {15'd0, r}, 16'd0);
    end
    bit_io(1'b1, r);
    chk(r == 1'b1, "R9 released on ninth clock", {15'd0, r}, 16'd1);
    stop_c();
    wq(10);
    chk(sda_oe == 1'b0, "R9 idle after stop", {15'd0, sda_oe}, 16'd0);
    rd_reg(2'b10, 1'b0, 16'h3C00, 1'b1, "R9 R3 recovered read");

    wq(40);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule